// File: doc/BRIEF.md
# POST-Code Status LED Controller

This block drives four bicolour (red and green) front-panel status LEDs. After power-up it works as a fault display. Four board-status inputs each light one LED in red. The first write seen on the port-80 POST-code strobe ends the fault display for good. From then on an 8-bit mode register chooses what the LEDs show.

In POST-code mode, the last captured POST code is shown in green only, one nibble at a time. The upper nibble is shown first, then the lower nibble, then all LEDs go dark for a pause, and the cycle repeats. In host mode, firmware drives each LED's red and green enables directly, so an LED can show red, green, or both at once. Every other mode value turns all LEDs off.

The nibble timing comes from a prescaler, set by `TICK_DIV`. Each phase lasts a whole number of prescaler ticks: `HI_TICKS` for the upper nibble, `LO_TICKS` for the lower nibble and `GAP_TICKS` for the pause.

The sequencer is a four-state machine:
- `SQ_DEBUG` is the fault display from reset. It is left only by a port-80 write.
- `SQ_HIGH` shows the upper nibble.
- `SQ_LOW` shows the lower nibble.
- `SQ_GAP` is the dark pause.

The machine moves SQ_HIGH to SQ_LOW, SQ_LOW to SQ_GAP and SQ_GAP to SQ_HIGH, each at the end of its phase. A port-80 write in any state forces SQ_HIGH with the new code.

Top module: `post_led_ctrl`

## Requirements
- R1: After reset the mode register reads 0x00 and the LEDs show the fault display.
- R2: The mode register is 8 bits wide. Bits 3..0 are read/write. Bits 7..4 always read zero, and writes to them are ignored.
- R3: Until the first port-80 write, green is off and red is on for each active fault, whatever the mode. The mapping is: LED3 for power-good not reached, LED2 for processor catastrophic error, LED1 for hardware reset still asserted, LED0 for boot failure.
- R4: After the first port-80 write the fault inputs no longer affect the LEDs. This state holds until the next reset.
- R5: In mode 0000, LED n shows bit n+4 of the code in green for HI_TICKS*TICK_DIV cycles. This starts in the cycle after the port-80 write.
- R6: The upper-nibble phase is followed by LED n showing bit n in green for LO_TICKS*TICK_DIV cycles. All LEDs are then dark for GAP_TICKS*TICK_DIV cycles, and the sequence repeats.
- R7: A port-80 write latches the new code and restarts the sequence at the upper-nibble phase in the next cycle.
- R8: In mode 0001, led_red equals host_red and led_grn equals host_grn.
- R9: Mode values 0010 through 1111 turn every LED off.
- R10: Red is never lit in mode 0000 once the fault display has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the mode register |
| reg_wdata | input | 8 | Mode register write data |
| reg_rdata | output | 8 | Mode register read data |
| p80_wr | input | 1 | POST-code write strobe |
| p80_data | input | 8 | POST-code value |
| host_red | input | 4 | Host red enables, one per LED |
| host_grn | input | 4 | Host green enables, one per LED |
| flt_pwr_not_good | input | 1 | Power-good not reached |
| flt_cpu_cat | input | 1 | Processor catastrophic error |
| flt_hw_rst | input | 1 | Hardware reset still active |
| flt_boot_fail | input | 1 | Boot failure |
| led_red | output | 4 | Red enable for LED3..LED0 |
| led_grn | output | 4 | Green enable for LED3..LED0 |

## Verification
The POST-code sequence is driven with codes whose two nibbles differ (0xA5, 0x3C) and with all-ones and all-zero codes. The differing nibbles catch a swapped or shifted nibble, and the all-ones and all-zero codes catch phases that are too long or too short against the dark pause. Restarts are issued inside the upper-nibble phase and inside the lower-nibble phase, which shows whether the prescaler and phase counters really clear. Fault patterns are changed both before and after the first port-80 write, with a non-zero mode already written, so that a wrong exit from the fault display shows up. Host patterns and several reserved mode values then check the mode decode.

// File: rtl/post_led_pkg.sv
package post_led_pkg;

    typedef enum logic [1:0] {
        SQ_DEBUG = 2'd0,
        SQ_HIGH  = 2'd1,
        SQ_LOW   = 2'd2,
        SQ_GAP   = 2'd3
    } seq_state_t;

    localparam int MODE_W = 4;
    localparam int LED_N  = 4;
    localparam logic [MODE_W-1:0] MODE_POST = 4'd0;
    localparam logic [MODE_W-1:0] MODE_HOST = 4'd1;

endpackage

// File: rtl/led_mode_reg.sv
module led_mode_reg
    import post_led_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [MODE_W-1:0] mode,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - MODE_W;

    logic [MODE_W-1:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_en) begin
            mode_q <= wdata[MODE_W-1:0];
        end
    end

    assign mode  = mode_q;
    assign rdata = {{PAD_W{1'b0}}, mode_q};

endmodule

// File: rtl/post_nibble_seq.sv
module post_nibble_seq
    import post_led_pkg::*;
#(
    parameter int TICK_DIV  = 1000000,
    parameter int HI_TICKS  = 4,
    parameter int LO_TICKS  = 4,
    parameter int GAP_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       p80_wr,
    input  logic [7:0] p80_data,
    output seq_state_t state,
    output logic [7:0] code
);
    localparam int PRE_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int MAXT_A = (HI_TICKS > LO_TICKS) ? HI_TICKS : LO_TICKS;
    localparam int MAXT   = (MAXT_A > GAP_TICKS) ? MAXT_A : GAP_TICKS;
    localparam int PH_W   = (MAXT > 1) ? $clog2(MAXT) : 1;

    seq_state_t state_q, state_d;
    logic [PRE_W-1:0] pre_q;
    logic [PH_W-1:0]  ph_q;
    logic [PH_W-1:0]  ph_last;
    logic [7:0]       code_q;
    logic             tick;
    logic             phase_end;

    always_comb begin
        unique case (state_q)
            SQ_HIGH: ph_last = PH_W'(HI_TICKS - 1);
            SQ_LOW:  ph_last = PH_W'(LO_TICKS - 1);
            SQ_GAP:  ph_last = PH_W'(GAP_TICKS - 1);
            default: ph_last = '0;
        endcase
    end

    assign tick      = (state_q != SQ_DEBUG) && (pre_q == PRE_W'(TICK_DIV - 1));
    assign phase_end = tick && (ph_q == ph_last);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_DEBUG: state_d = SQ_DEBUG;
            SQ_HIGH:  if (phase_end) state_d = SQ_LOW;
            SQ_LOW:   if (phase_end) state_d = SQ_GAP;
            SQ_GAP:   if (phase_end) state_d = SQ_HIGH;
            default:  state_d = SQ_DEBUG;
        endcase
        if (p80_wr) begin
            state_d = SQ_HIGH;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_DEBUG;
        end else begin
            state_q <= state_d;
        end
    end

    // timing counters and code capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            ph_q   <= '0;
            code_q <= '0;
        end else if (p80_wr) begin
            pre_q  <= '0;
            ph_q   <= '0;
            code_q <= p80_data;
        end else if (state_q != SQ_DEBUG) begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) begin
                ph_q <= phase_end ? '0 : ph_q + 1'b1;
            end
        end
    end

    assign state = state_q;
    assign code  = code_q;

endmodule

// File: rtl/led_out_mux.sv
module led_out_mux
    import post_led_pkg::*;
(
    input  seq_state_t        state,
    input  logic [MODE_W-1:0] mode,
    input  logic [7:0]        code,
    input  logic [LED_N-1:0]  host_red,
    input  logic [LED_N-1:0]  host_grn,
    input  logic [LED_N-1:0]  fault,
    output logic [LED_N-1:0]  led_red,
    output logic [LED_N-1:0]  led_grn
);
    logic [LED_N-1:0] nib;

    always_comb begin
        unique case (state)
            SQ_HIGH: nib = code[7:4];
            SQ_LOW:  nib = code[3:0];
            default: nib = '0;
        endcase
    end

    // output process
    always_comb begin
        led_red = '0;
        led_grn = '0;
        if (state == SQ_DEBUG) begin
            led_red = fault;
        end else if (mode == MODE_POST) begin
            led_grn = nib;
        end else if (mode == MODE_HOST) begin
            led_red = host_red;
            led_grn = host_grn;
        end
    end

endmodule

// File: rtl/post_led_ctrl.sv
module post_led_ctrl
    import post_led_pkg::*;
#(
    parameter int TICK_DIV  = 1000000,
    parameter int HI_TICKS  = 4,
    parameter int LO_TICKS  = 4,
    parameter int GAP_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       p80_wr,
    input  logic [7:0] p80_data,
    input  logic [3:0] host_red,
    input  logic [3:0] host_grn,
    input  logic       flt_pwr_not_good,
    input  logic       flt_cpu_cat,
    input  logic       flt_hw_rst,
    input  logic       flt_boot_fail,
    output logic [3:0] led_red,
    output logic [3:0] led_grn
);
    logic [MODE_W-1:0] cfg_mode;
    seq_state_t        seq_state;
    logic [7:0]        seq_code;
    logic [LED_N-1:0]  fault_vec;

    assign fault_vec = {flt_pwr_not_good, flt_cpu_cat, flt_hw_rst, flt_boot_fail};

    led_mode_reg #(.DATA_W(8)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .wdata (reg_wdata),
        .mode  (cfg_mode),
        .rdata (reg_rdata)
    );

    post_nibble_seq #(
        .TICK_DIV  (TICK_DIV),
        .HI_TICKS  (HI_TICKS),
        .LO_TICKS  (LO_TICKS),
        .GAP_TICKS (GAP_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .p80_wr   (p80_wr),
        .p80_data (p80_data),
        .state    (seq_state),
        .code     (seq_code)
    );

    led_out_mux u_mux (
        .state    (seq_state),
        .mode     (cfg_mode),
        .code     (seq_code),
        .host_red (host_red),
        .host_grn (host_grn),
        .fault    (fault_vec),
        .led_red  (led_red),
        .led_grn  (led_grn)
    );

endmodule

// File: rtl/post_led_chk.sv
module post_led_chk
    import post_led_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              p80_wr,
    input seq_state_t        seq_state,
    input logic [MODE_W-1:0] cfg_mode,
    input logic [7:0]        reg_rdata,
    input logic [3:0]        led_red,
    input logic [3:0]        led_grn
);
    // R2
    upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:4] == 4'h0);

    // R3
    debug_no_green_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SQ_DEBUG) |-> (led_grn == 4'h0));

    // R4
    debug_exit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != SQ_DEBUG) |=> (seq_state != SQ_DEBUG));

    // R7
    restart_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p80_wr |=> (seq_state == SQ_HIGH));

    // R6
    gap_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SQ_GAP && cfg_mode == MODE_POST) |-> (led_grn == 4'h0));

    // R9
    reserved_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != SQ_DEBUG && cfg_mode > MODE_HOST) |-> (led_red == 4'h0 && led_grn == 4'h0));

    // R10
    post_no_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != SQ_DEBUG && cfg_mode == MODE_POST) |-> (led_red == 4'h0));

endmodule

bind post_led_ctrl post_led_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .p80_wr    (p80_wr),
    .seq_state (seq_state),
    .cfg_mode  (cfg_mode),
    .reg_rdata (reg_rdata),
    .led_red   (led_red),
    .led_grn   (led_grn)
);

// File: tb/sim_post_led_ctrl.sv
`timescale 1ns/1ps
module sim_post_led_ctrl;
    localparam int DIV = 3;
    localparam int HI  = 2;
    localparam int LO  = 2;
    localparam int GP  = 1;
    localparam int HI_END = HI * DIV;
    localparam int LO_END = (HI + LO) * DIV;
    localparam int PERIOD = (HI + LO + GP) * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic p80_wr = 1'b0;
    logic [7:0] p80_data = '0;
    logic [3:0] host_red = '0;
    logic [3:0] host_grn = '0;
    logic flt_pwr_not_good = 1'b0;
    logic flt_cpu_cat = 1'b0;
    logic flt_hw_rst = 1'b0;
    logic flt_boot_fail = 1'b0;
    logic [3:0] led_red, led_grn;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    post_led_ctrl #(.TICK_DIV(DIV), .HI_TICKS(HI), .LO_TICKS(LO), .GAP_TICKS(GP)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .p80_wr(p80_wr), .p80_data(p80_data),
        .host_red(host_red), .host_grn(host_grn),
        .flt_pwr_not_good(flt_pwr_not_good), .flt_cpu_cat(flt_cpu_cat),
        .flt_hw_rst(flt_hw_rst), .flt_boot_fail(flt_boot_fail),
        .led_red(led_red), .led_grn(led_grn)
    );

    // behavioural reference model
    logic [3:0] m_mode;
    bit         m_seen;
    logic [7:0] m_code;
    int         m_e;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode <= '0; m_seen <= 0; m_code <= '0; m_e <= 0;
        end else begin
            if (reg_wr_en) m_mode <= reg_wdata[3:0];
            if (p80_wr) begin
                m_seen <= 1; m_code <= p80_data; m_e <= 0;
            end else if (m_seen) begin
                m_e <= (m_e + 1) % PERIOD;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] er, eg;
            string tag;
            er = '0; eg = '0;
            if (!m_seen) begin
                er = {flt_pwr_not_good, flt_cpu_cat, flt_hw_rst, flt_boot_fail};
                tag = "R3";
            end else if (m_mode == 4'd0) begin
                if (m_e < HI_END) begin eg = m_code[7:4]; tag = "R5"; end
                else if (m_e < LO_END) begin eg = m_code[3:0]; tag = "R6"; end
                else tag = "R6";
                // R10: no red in POST mode
                chk(led_red == 4'h0, "R10", led_red, 0);
            end else if (m_mode == 4'd1) begin
                er = host_red; eg = host_grn; tag = "R8";
            end else begin
                tag = "R9";
            end
            chk({led_red, led_grn} == {er, eg}, tag, {led_red, led_grn}, {er, eg});
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            reg_wr_en = 1'b0; p80_wr = 1'b0;
        end
    endtask

    task automatic cfg_write(input logic [7:0] v);
        reg_wr_en = 1'b1; reg_wdata = v; step();
    endtask

    task automatic post_write(input logic [7:0] v);
        p80_wr = 1'b1; p80_data = v; step();
    endtask

    task automatic set_faults(input logic [3:0] f);
        {flt_pwr_not_good, flt_cpu_cat, flt_hw_rst, flt_boot_fail} = f;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; #13; rst_n = 1'b1; step();
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1; do_reset();
        // R1: reset state
        #1; chk(reg_rdata == 8'h00, "R1", reg_rdata, 0);
        chk(led_grn == 4'h0 && led_red == 4'h0, "R1", {led_red, led_grn}, 0);
        set_faults(4'b1000); step(2);
        set_faults(4'b0101); step(2);
        set_faults(4'b1111); step(2);
        // R2: upper bits dropped; mode ignored during fault display
        cfg_write(8'hF1);
        #1; chk(reg_rdata == 8'h01, "R2", reg_rdata, 8'h01);
        set_faults(4'b0010); step(3);
        cfg_write(8'h00);
        #1; chk(reg_rdata == 8'h00, "R2", reg_rdata, 0);
        // leave fault display
        post_write(8'hA5);
        set_faults(4'b1111); step(1);
        #1; chk(led_red == 4'h0, "R4", led_red, 0);
        step(2 * PERIOD);
        // restart inside upper-nibble phase
        post_write(8'h3C); step(2);
        post_write(8'h96);
        #1; chk(led_grn == 4'h9, "R7", led_grn, 4'h9);
        step(HI_END + 1);
        // restart inside lower-nibble phase
        post_write(8'h3C);
        #1; chk(led_grn == 4'h3, "R7", led_grn, 4'h3);
        step(PERIOD + 2);
        post_write(8'hFF); step(PERIOD);
        post_write(8'h00); step(PERIOD);
        set_faults(4'b0000); step(3);
        #1; chk(led_red == 4'h0, "R4", led_red, 0);
        // host mode
        cfg_write(8'h01);
        host_red = 4'b1010; host_grn = 4'b0110; step(2);
        host_red = 4'b1111; host_grn = 4'b1111; step(2);
        host_red = 4'b0001; host_grn = 4'b1000; step(2);
        // reserved modes
        cfg_write(8'h02); step(3);
        cfg_write(8'h07); step(3);
        cfg_write(8'h0F); step(3);
        #1; chk(reg_rdata == 8'h0F, "R2", reg_rdata, 8'h0F);
        cfg_write(8'h00); step(PERIOD);
        // reset brings back fault display
        set_faults(4'b0110);
        do_reset();
        #1; chk(reg_rdata == 8'h00, "R1", reg_rdata, 0);
        chk(led_red == 4'b0110, "R1", led_red, 4'b0110);
        step(4);
        post_write(8'h5A); step(PERIOD);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule